// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in first-out buffer whose write port and read port run on separate, unrelated clocks. Neither clock is constrained in frequency relative to the other. The depth is a power-of-two parameter. The write pointer crosses into the read domain, and the read pointer into the write domain, as Gray code through two-flop synchronisers. The write domain computes the full, half-full and almost-full indications. The read domain computes empty and almost-empty.

Two thresholds set the almost flags: an empty offset and a full offset. A master reset loads both thresholds with one of two preset values, chosen by a strap input. Software-free programming is also possible. The thresholds can be shifted in one bit per write clock, or loaded from the data bus while a load input is held. A partial reset empties the buffer and keeps the thresholds.

A mode strap, sampled during master reset, picks one of two read-side behaviours. In standard timing, a read request loads the output register on the next read clock. In fall-through timing, the oldest word moves to the output by itself and a valid indication marks it. A retransmit input rewinds reading to the first word written since the last reset. An output enable gates the data output and drives a tristate control.

The read side is a state machine with three states:
- `RS_STD`: standard timing.
- `RS_FW_EMPTY`: fall-through mode with no word held.
- `RS_FW_HOLD`: fall-through mode with a word presented on the output.

In the read state machine:
- `RS_FW_EMPTY` goes to `RS_FW_HOLD` when the memory holds a word.
- `RS_FW_HOLD` goes to `RS_FW_EMPTY` on a read when the memory is empty, or on retransmit.
- `RS_STD` only changes at master reset.

The parallel-load selector is a second state machine with two states:
- `LS_EMPTY`: the next load goes to the empty threshold.
- `LS_FULL`: the next load goes to the full threshold.

In the parallel-load selector:
- `LS_EMPTY` goes to `LS_FULL` on a load write.
- `LS_FULL` goes back to `LS_EMPTY` on the next load write, or when `ld` drops.

Top module: `dcf_fifo`

## Requirements
- R1: After a master or a partial reset, the buffer is empty:
  - `rd_stat` is 1 in standard timing.
  - `wr_stat`, `half_full` and `almost_full` are 0.
  - `almost_empty` is 1.
  - `dout` is 0.
- R2: Words are read in the order they were written. In standard timing, with `rd_stat` = 1 meaning empty, the word taken by a read-clock edge with `ren` high appears on `dout` after that same edge.
- R3: A write while the buffer holds DEPTH words is dropped. A read while it is empty leaves `dout` unchanged. Neither disturbs the words that follow.
- R4: `wr_stat` in standard timing is 1 exactly when DEPTH words are stored. `half_full` is 1 exactly when more than DEPTH/2 words are stored.
- R5: `almost_empty` is 1 when the stored count is at or below the empty threshold. `almost_full` is 1 when DEPTH minus the stored count is at or below the full threshold.
- R6: Master reset loads both thresholds with OFF_A when `preset_sel` is 0, and with OFF_B when it is 1.
- R7: Each write-clock edge with `sen` high and `ld` low shifts `ser_in` into a 2*AW-bit threshold chain. The bit order is: empty threshold LSB first, then full threshold LSB first.
- R8: While `ld` is high, each write-clock edge with `wen` high does two things. It stores `din[AW-1:0]` into a threshold: first the empty threshold, then the full threshold, alternately. It writes no data into the buffer. Dropping `ld` returns the selection to the empty threshold.
- R9: A partial reset keeps the programmed thresholds. A master reset restores the presets.
- R10: With `fwft_sel` high during master reset, the read side runs in fall-through timing:
  - The oldest word appears on `dout` without a read, and `rd_stat` = 1 marks it valid.
  - A read advances to the next word, or clears `rd_stat` when none is left.
  - `wr_stat` = 1 means room is available in the memory.
- R11: A one-cycle `rt` pulse sets the read position back to the first word written since the last reset, and the following reads replay the data. This holds with writes idle and at most DEPTH writes since the reset.
- R12: With `oe` low, `dout` is 0 and `dout_en` is 0. The buffer contents and read position are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| mrs_n | input | 1 | Master reset, active low, held over edges of both clocks |
| prs_n | input | 1 | Partial reset, active low, held over edges of both clocks |
| fwft_sel | input | 1 | Timing mode strap, sampled during master reset (1 = fall-through) |
| preset_sel | input | 1 | Preset threshold strap, sampled during master reset |
| wen | input | 1 | Write enable |
| din | input | 18 | Write data; low AW bits also carry parallel threshold loads |
| ld | input | 1 | Parallel threshold load |
| sen | input | 1 | Serial threshold shift enable |
| ser_in | input | 1 | Serial threshold data |
| rclk | input | 1 | Read clock |
| ren | input | 1 | Read enable |
| rt | input | 1 | Retransmit request |
| oe | input | 1 | Output enable |
| dout | output | 18 | Read data, zero while oe is low |
| dout_en | output | 1 | Tristate control for an output pad |
| wr_stat | output | 1 | Full (standard) or room available (fall-through) |
| rd_stat | output | 1 | Empty (standard) or output word valid (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored |
| almost_full | output | 1 | Free space at or below the full threshold |
| almost_empty | output | 1 | Stored count at or below the empty threshold |

## Verification
The hardest situations to reach are the flag boundaries with every programmed threshold. Each boundary depends on an exact fill level, and each fill level must settle across both synchronisers before the flags are meaningful. The bench reaches them by sweeping every fill level from 0 to DEPTH under each threshold source in turn: both presets, serial programming and parallel loading. A partial reset comes before each level, so the same sweep also shows that partial reset keeps the thresholds. At the full level the sweep adds an overflow write, and after draining it adds an underflow read. Retransmit and fall-through timing get dedicated sequences with read and write clocks of unrelated periods.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    typedef enum logic [1:0] {
        RS_STD      = 2'd0,
        RS_FW_EMPTY = 2'd1,
        RS_FW_HOLD  = 2'd2
    } rd_state_t;

    typedef enum logic {
        LS_EMPTY = 1'b0,
        LS_FULL  = 1'b1
    } ld_state_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i + 1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int W  = 18,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int N = 1 << AW;

    logic [W-1:0] store [N];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int OFF_A = 7,
    parameter int OFF_B = 63,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          mrs_n,
    input  logic          prs_n,
    input  logic          fwft_sel,
    input  logic          preset_sel,
    input  logic          wen,
    input  logic          ld,
    input  logic          sen,
    input  logic          ser_in,
    input  logic [AW-1:0] ld_data,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [AW-1:0] eoff,
    output logic          wr_stat,
    output logic          half_full,
    output logic          almost_full
);
    localparam logic [AW-1:0] PRE_A  = AW'(OFF_A);
    localparam logic [AW-1:0] PRE_B  = AW'(OFF_B);
    localparam logic [AW:0]   CAP    = (AW+1)'(DEPTH);
    localparam logic [AW:0]   HALF   = (AW+1)'(DEPTH / 2);

    ld_state_t     ld_st, ld_nx;
    logic          wmode;
    logic [AW-1:0] foff;
    logic [AW:0]   wptr, wptr_nx, rbin, cnt, space;
    logic          full, accept;

    // Load selector state register
    always_ff @(posedge wclk) begin
        if (!mrs_n || !prs_n) ld_st <= LS_EMPTY;
        else                  ld_st <= ld_nx;
    end

    always_comb begin
        ld_nx = ld_st;
        unique case (ld_st)
            LS_EMPTY: ld_nx = (ld && wen) ? LS_FULL : LS_EMPTY;
            LS_FULL:  ld_nx = (!ld || wen) ? LS_EMPTY : LS_FULL;
            default:  ld_nx = LS_EMPTY;
        endcase
    end

    // Mode strap and thresholds
    always_ff @(posedge wclk) begin
        if (!mrs_n) begin
            wmode <= fwft_sel;
            eoff  <= preset_sel ? PRE_B : PRE_A;
            foff  <= preset_sel ? PRE_B : PRE_A;
        end else if (ld && wen) begin
            if (ld_st == LS_EMPTY) eoff <= ld_data;
            else                   foff <= ld_data;
        end else if (sen && !ld) begin
            {foff, eoff} <= {ser_in, foff, eoff[AW-1:1]};
        end
    end

    // Occupancy
    always_comb begin
        rbin   = (AW+1)'(gray2bin(32'(rgray_s)));
        cnt    = wptr - rbin;
        space  = CAP - cnt;
        full   = (cnt == CAP);
        accept = wen && !ld && !full;
        wptr_nx = wptr + (AW+1)'(accept);
    end

    always_ff @(posedge wclk) begin
        if (!mrs_n || !prs_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else begin
            wptr  <= wptr_nx;
            wgray <= (AW+1)'(bin2gray(32'(wptr_nx)));
        end
    end

    // Outputs
    always_comb begin
        mem_we      = accept;
        waddr       = wptr[AW-1:0];
        wr_stat     = wmode ? !full : full;
        half_full   = (cnt > HALF);
        almost_full = (space <= {1'b0, foff});
    end

    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
        (wen && !ld && full) |=> (wptr == $past(wptr)));

    p_load_no_write_r8: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
        ld |=> (wptr == $past(wptr)));

    p_full_flags_r4: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
        full |-> (half_full && almost_full));

    p_count_bound_r4: assert property (@(posedge wclk) disable iff (!mrs_n || !prs_n)
        cnt <= CAP);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int W     = 18,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          rclk,
    input  logic          mrs_n,
    input  logic          prs_n,
    input  logic          fwft_sel,
    input  logic          ren,
    input  logic          rt,
    input  logic [AW:0]   wgray_s,
    input  logic [AW-1:0] eoff_s,
    input  logic [W-1:0]  mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [W-1:0]  q,
    output logic          rd_stat,
    output logic          almost_empty
);
    rd_state_t   st, st_nx;
    logic [AW:0] rptr, rptr_nx, wbin, cnt;
    logic        mem_empty, fetch;

    always_comb begin
        wbin      = (AW+1)'(gray2bin(32'(wgray_s)));
        cnt       = wbin - rptr;
        mem_empty = (cnt == '0);
    end

    // State register
    always_ff @(posedge rclk) begin
        if (!mrs_n)      st <= fwft_sel ? RS_FW_EMPTY : RS_STD;
        else if (!prs_n) st <= (st == RS_STD) ? RS_STD : RS_FW_EMPTY;
        else             st <= st_nx;
    end

    // Next state and pointer moves
    always_comb begin
        st_nx   = st;
        fetch   = 1'b0;
        rptr_nx = rptr;
        unique case (st)
            RS_STD: begin
                if (rt)                     rptr_nx = '0;
                else if (ren && !mem_empty) fetch = 1'b1;
            end
            RS_FW_EMPTY: begin
                if (rt) begin
                    rptr_nx = '0;
                end else if (!mem_empty) begin
                    fetch = 1'b1;
                    st_nx = RS_FW_HOLD;
                end
            end
            RS_FW_HOLD: begin
                if (rt) begin
                    rptr_nx = '0;
                    st_nx   = RS_FW_EMPTY;
                end else if (ren) begin
                    if (!mem_empty) fetch = 1'b1;
                    else            st_nx = RS_FW_EMPTY;
                end
            end
            default: st_nx = RS_STD;
        endcase
        if (fetch) rptr_nx = rptr + 1'b1;
    end

    always_ff @(posedge rclk) begin
        if (!mrs_n || !prs_n) begin
            rptr  <= '0;
            rgray <= '0;
            q     <= '0;
        end else begin
            rptr  <= rptr_nx;
            rgray <= (AW+1)'(bin2gray(32'(rptr_nx)));
            if (fetch) q <= mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        raddr        = rptr[AW-1:0];
        rd_stat      = (st == RS_STD) ? mem_empty : (st == RS_FW_HOLD);
        almost_empty = (cnt <= {1'b0, eoff_s});
    end

    p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        (st == RS_STD && ren && !rt && mem_empty) |=> (rptr == $past(rptr) && $stable(q)));

    p_empty_is_almost_r5: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        mem_empty |-> almost_empty);

    p_fwft_hold_r10: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        (st == RS_FW_HOLD && !ren && !rt) |=> $stable(q));

    p_mode_kept_r9: assert property (@(posedge rclk) disable iff (!mrs_n)
        (st == RS_STD) |=> (st == RS_STD));

    p_rewind_r11: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        rt |=> (rptr == '0));
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 256,
    parameter int OFF_A = 7,
    parameter int OFF_B = 63
) (
    input  logic             wclk,
    input  logic             mrs_n,
    input  logic             prs_n,
    input  logic             fwft_sel,
    input  logic             preset_sel,
    input  logic             wen,
    input  logic [WIDTH-1:0] din,
    input  logic             ld,
    input  logic             sen,
    input  logic             ser_in,
    input  logic             rclk,
    input  logic             ren,
    input  logic             rt,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             wr_stat,
    output logic             rd_stat,
    output logic             half_full,
    output logic             almost_full,
    output logic             almost_empty
);
    localparam int AW = $clog2(DEPTH);

    logic            mem_we;
    logic [AW-1:0]   waddr, raddr, eoff, eoff_s;
    logic [AW:0]     wgray, rgray, wgray_s, rgray_s;
    logic [WIDTH-1:0] mem_rdata, q;
    logic            clr_n;

    assign clr_n = mrs_n && prs_n;

    dcf_ram #(.W(WIDTH), .AW(AW)) u_ram (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    dcf_sync #(.W(AW + 1)) u_sync_r2w (
        .clk (wclk), .clr_n (clr_n), .d (rgray), .q (rgray_s)
    );

    dcf_sync #(.W(AW + 1)) u_sync_w2r (
        .clk (rclk), .clr_n (clr_n), .d (wgray), .q (wgray_s)
    );

    dcf_sync #(.W(AW)) u_sync_eoff (
        .clk (rclk), .clr_n (mrs_n), .d (eoff), .q (eoff_s)
    );

    dcf_wr_ctrl #(.DEPTH(DEPTH), .OFF_A(OFF_A), .OFF_B(OFF_B)) u_wr (
        .wclk        (wclk),
        .mrs_n       (mrs_n),
        .prs_n       (prs_n),
        .fwft_sel    (fwft_sel),
        .preset_sel  (preset_sel),
        .wen         (wen),
        .ld          (ld),
        .sen         (sen),
        .ser_in      (ser_in),
        .ld_data     (din[AW-1:0]),
        .rgray_s     (rgray_s),
        .mem_we      (mem_we),
        .waddr       (waddr),
        .wgray       (wgray),
        .eoff        (eoff),
        .wr_stat     (wr_stat),
        .half_full   (half_full),
        .almost_full (almost_full)
    );

    dcf_rd_ctrl #(.W(WIDTH), .DEPTH(DEPTH)) u_rd (
        .rclk         (rclk),
        .mrs_n        (mrs_n),
        .prs_n        (prs_n),
        .fwft_sel     (fwft_sel),
        .ren          (ren),
        .rt           (rt),
        .wgray_s      (wgray_s),
        .eoff_s       (eoff_s),
        .mem_rdata    (mem_rdata),
        .raddr        (raddr),
        .rgray        (rgray),
        .q            (q),
        .rd_stat      (rd_stat),
        .almost_empty (almost_empty)
    );

    assign dout    = oe ? q : '0;
    assign dout_en = oe;

    p_oe_gate_r12: assert property (@(posedge rclk) disable iff (!mrs_n || !prs_n)
        !dout_en |-> (dout == '0));
endmodule

// File: tb/test_dcf_fifo.sv
module test_dcf_fifo;
    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int OFF_A = 2;
    localparam int OFF_B = 6;

    logic        wclk = 1'b0, rclk = 1'b0;
    logic        mrs_n = 1'b0, prs_n = 1'b1, fwft_sel = 1'b0, preset_sel = 1'b0;
    logic        wen = 1'b0, ld = 1'b0, sen = 1'b0, ser_in = 1'b0;
    logic [17:0] din = '0;
    logic        ren = 1'b0, rt = 1'b0, oe = 1'b1;
    logic [17:0] dout;
    logic        dout_en, wr_stat, rd_stat, half_full, almost_full, almost_empty;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 wclk = ~wclk;
    always #6.5 rclk = ~rclk;

    dcf_fifo #(.WIDTH(18), .DEPTH(DEPTH), .OFF_A(OFF_A), .OFF_B(OFF_B)) i_dcf_fifo (
        .wclk(wclk), .mrs_n(mrs_n), .prs_n(prs_n), .fwft_sel(fwft_sel),
        .preset_sel(preset_sel), .wen(wen), .din(din), .ld(ld), .sen(sen),
        .ser_in(ser_in), .rclk(rclk), .ren(ren), .rt(rt), .oe(oe),
        .dout(dout), .dout_en(dout_en), .wr_stat(wr_stat), .rd_stat(rd_stat),
        .half_full(half_full), .almost_full(almost_full), .almost_empty(almost_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [17:0] pat(input int n, input int i);
        return 18'((n * 37 + i * 5 + 1) ^ 18'h2A5A5);
    endfunction

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic do_mrs(input logic fw, input logic ps);
        @(negedge wclk);
        fwft_sel = fw; preset_sel = ps; mrs_n = 1'b0;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        mrs_n = 1'b1;
        settle();
    endtask

    task automatic do_prs();
        @(negedge wclk);
        prs_n = 1'b0;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        prs_n = 1'b1;
        settle();
    endtask

    task automatic wr_word(input logic [17:0] v);
        @(negedge wclk);
        wen = 1'b1; din = v;
        @(negedge wclk);
        wen = 1'b0;
    endtask

    task automatic rd_pulse();
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
    endtask

    // Standard-timing sweep over every fill level with thresholds eo/fo
    task automatic sweep(input int eo, input int fo, input string tag);
        for (int n = 0; n <= DEPTH; n++) begin
            do_prs();
            for (int i = 0; i < n; i++) wr_word(pat(n, i));
            settle();
            chk("R4 empty", 32'(rd_stat), 32'(n == 0));
            chk("R4 full", 32'(wr_stat), 32'(n == DEPTH));
            chk("R4 half", 32'(half_full), 32'(n > DEPTH / 2));
            chk({"R5 almost_empty ", tag}, 32'(almost_empty), 32'(n <= eo));
            chk({"R5 almost_full ", tag}, 32'(almost_full), 32'((DEPTH - n) <= fo));
            if (n == DEPTH) begin
                wr_word(18'h3FFFF);
                settle();
                chk("R3 full after overflow", 32'(wr_stat), 32'd1);
            end
            for (int i = 0; i < n; i++) begin
                rd_pulse();
                chk("R2 data order", 32'(dout), 32'(pat(n, i)));
            end
            settle();
            chk("R3 empty after drain", 32'(rd_stat), 32'd1);
            if (n > 0) begin
                rd_pulse();
                chk("R3 read on empty holds", 32'(dout), 32'(pat(n, n - 1)));
            end
            if (n == DEPTH) begin
                wr_word(18'h0ABCD);
                settle();
                rd_pulse();
                chk("R3 pointers intact", 32'(dout), 32'h0ABCD);
            end
        end
    endtask

    task automatic serial_prog(input int eo, input int fo);
        logic [2*AW-1:0] bits;
        bits = {AW'(fo), AW'(eo)};
        for (int i = 0; i < 2 * AW; i++) begin
            @(negedge wclk);
            sen = 1'b1; ser_in = bits[i];
        end
        @(negedge wclk);
        sen = 1'b0;
        settle();
    endtask

    task automatic par_prog(input int eo, input int fo);
        @(negedge wclk);
        ld = 1'b1; wen = 1'b1; din = 18'(eo);
        @(negedge wclk);
        din = 18'(fo);
        @(negedge wclk);
        wen = 1'b0; ld = 1'b0;
        settle();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        do_mrs(1'b0, 1'b0);
        // R1 reset state
        chk("R1 rd_stat", 32'(rd_stat), 32'd1);
        chk("R1 wr_stat", 32'(wr_stat), 32'd0);
        chk("R1 half_full", 32'(half_full), 32'd0);
        chk("R1 almost_full", 32'(almost_full), 32'd0);
        chk("R1 almost_empty", 32'(almost_empty), 32'd1);
        chk("R1 dout", 32'(dout), 32'd0);

        // R6 preset A then preset B
        sweep(OFF_A, OFF_A, "R6");
        do_mrs(1'b0, 1'b1);
        sweep(OFF_B, OFF_B, "R6");

        // R7 serial thresholds; the sweep's partial resets also show R9
        serial_prog(3, 9);
        sweep(3, 9, "R7");

        // R8 parallel load: no data enters the buffer
        par_prog(11, 1);
        chk("R8 no data written", 32'(rd_stat), 32'd1);
        sweep(11, 1, "R8");

        // R9 master reset restores presets
        do_mrs(1'b0, 1'b0);
        sweep(OFF_A, OFF_A, "R9");

        // R11 retransmit
        do_prs();
        for (int i = 0; i < 5; i++) wr_word(pat(40, i));
        settle();
        for (int i = 0; i < 5; i++) begin
            rd_pulse();
            chk("R11 first pass", 32'(dout), 32'(pat(40, i)));
        end
        @(negedge rclk); rt = 1'b1;
        @(negedge rclk); rt = 1'b0;
        settle();
        chk("R11 not empty after rewind", 32'(rd_stat), 32'd0);
        for (int i = 0; i < 5; i++) begin
            rd_pulse();
            chk("R11 replay", 32'(dout), 32'(pat(40, i)));
        end

        // R12 output enable
        do_prs();
        @(negedge rclk); oe = 1'b0;
        @(negedge rclk);
        chk("R12 dout gated", 32'(dout), 32'd0);
        chk("R12 dout_en low", 32'(dout_en), 32'd0);
        wr_word(18'h1234);
        settle();
        rd_pulse();
        chk("R12 dout gated after read", 32'(dout), 32'd0);
        oe = 1'b1;
        @(negedge rclk);
        chk("R12 dout_en high", 32'(dout_en), 32'd1);
        chk("R12 word kept", 32'(dout), 32'h1234);

        // R10 fall-through timing
        do_mrs(1'b1, 1'b0);
        chk("R10 no word valid", 32'(rd_stat), 32'd0);
        chk("R10 room", 32'(wr_stat), 32'd1);
        for (int i = 0; i < 3; i++) wr_word(pat(50, i));
        settle();
        chk("R10 word valid", 32'(rd_stat), 32'd1);
        chk("R10 first word falls through", 32'(dout), 32'(pat(50, 0)));
        rd_pulse();
        chk("R10 second word", 32'(dout), 32'(pat(50, 1)));
        rd_pulse();
        chk("R10 third word", 32'(dout), 32'(pat(50, 2)));
        rd_pulse();
        chk("R10 valid cleared", 32'(rd_stat), 32'd0);
        wr_word(pat(50, 3));
        settle();
        chk("R10 refill falls through", 32'(dout), 32'(pat(50, 3)));
        for (int i = 0; i < DEPTH; i++) wr_word(pat(51, i));
        settle();
        chk("R10 no room", 32'(wr_stat), 32'd0);
        rd_pulse();
        chk("R10 next after fill", 32'(dout), 32'(pat(51, 0)));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule